// File: doc/BRIEF.md
# Isochronous Transmit Skip Sequencer

This block steps one isochronous transmit context through a chain of descriptor programs, one program per bus cycle. Each program is three 32-bit words at a 16-byte aligned base: a packet word at byte offset 0, a branch word at offset 4 and a skip word at offset 8. In an ordinary cycle the sequencer reads the packet word and the branch word, writes the packet word into the transmit FIFO and moves to the branch target. If a bus reset, a lost cycle or a transmit error has been seen since the last boundary, the sequencer reads only the skip word and moves there. No packet is written in that cycle.

Where the skip word points decides the recovery. If it points back at the current program, that packet is tried again in a later cycle. If it points at the following program, the current packet is dropped. If it points at an unrelated program, that program runs next and then follows its own branch. If its Z field is zero, the context ends. A branch word whose Z field is zero also ends the context. In that case the packet just written is still sent, and the context stays active until the FIFO reports empty.

A transmit error also flushes whatever the FIFO still holds. Dropping run stops the context at the next cycle start without flushing.

Top module: `iso_tx_skip_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, active, rd_req, fifo_we and fifo_flush are all 0.
- R2: A rising edge of run starts the context when the low 4 bits (Z field) of start_ptr are nonzero. The context starts at start_ptr with those 4 bits cleared, and active is 1 in the following cycle. If the Z field of start_ptr is zero, active stays 0.
- R3: At a cycle start with no event pending, the block reads the word at the program base and then the word at base+4. It writes the first word to the FIFO with exactly one fifo_we pulse. The next program is the branch word with its low 4 bits cleared.
- R4: At a cycle start with an event pending, the block reads only the word at base+8 and makes no FIFO write. The next program is that skip word with its low 4 bits cleared. An event that repeats every cycle therefore blocks writes in every one of those cycles.
- R5: A skip word that points at the current program makes the same packet word the next one written, in the first cycle that has no event.
- R6: A branch or skip word with a zero Z field (bits 3:0) ends the context, and no further reads are issued. active falls only once fifo_empty is high and no write is in flight. After a terminating branch, active therefore stays 1 until the written packet has left the FIFO.
- R7: A tx_error pulse while the context is active and run is high produces one fifo_flush pulse in the next cycle. The following cycle start then takes the skip path.
- R8: bus_reset, cycle_lost and tx_error are ignored while the context is idle. They cause no flush and no skip after a later start.
- R9: With run low at a cycle start, a waiting context goes idle with no read, no write and no flush.
- R10: rd_req stays high with a stable rd_addr until rd_valid. rd_data is taken only on a cycle where rd_valid is high, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Context enable; a rising edge starts the context |
| start_ptr | input | AW | First program address, Z field in bits 3:0 |
| active | output | 1 | Context is running or draining |
| cycle_start | input | 1 | One-clock pulse at each bus cycle boundary |
| bus_reset | input | 1 | Bus reset event pulse |
| cycle_lost | input | 1 | Lost cycle event pulse |
| tx_error | input | 1 | Transmit error event pulse |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor word byte address |
| rd_data | input | DW | Descriptor word returned |
| rd_valid | input | 1 | rd_data is valid this cycle |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | Packet word written to the FIFO |
| fifo_flush | output | 1 | Discard the FIFO contents |
| fifo_empty | input | 1 | FIFO holds no packet |

## Verification
Each bus cycle is driven as one unit: an optional event pulse, then a cycle_start pulse, then a fixed window of 16 clocks. Descriptor reads complete with a random latency of up to three clocks, so every fetch for the cycle, and the fifo_we pulse one clock after the branch word is accepted, land inside that window. Reads, writes and flushes are counted over the whole window. active is compared only at the window's end, after the drain decision has settled. fifo_flush is due one clock after tx_error, and it is counted in the same window.

// File: rtl/iso_skip_pkg.sv
package iso_skip_pkg;

    // Width of the target-valid field in branch and skip words
    localparam int ZW = 4;

    // Byte offsets of the three words of a program
    localparam int OFF_PAY  = 0;
    localparam int OFF_BR   = 4;
    localparam int OFF_SKIP = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_PAY,
        S_BR,
        S_SKIP,
        S_DRAIN
    } seq_state_e;

    function automatic logic z_valid(input logic [ZW-1:0] z);
        return z != '0;
    endfunction

endpackage

// File: rtl/iso_evt_latch.sv
module iso_evt_latch (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic bus_reset,
    input  logic cycle_lost,
    input  logic tx_error,
    input  logic take,
    output logic pend,
    output logic flush
);
    logic pend_q;
    logic evt_now;

    assign evt_now = bus_reset | cycle_lost | tx_error;
    assign pend    = live & (pend_q | evt_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            flush  <= 1'b0;
        end else begin
            flush <= tx_error & live;
            if (!live || take)
                pend_q <= 1'b0;
            else if (evt_now)
                pend_q <= 1'b1;
        end
    end

    // R7: a pending skip survives until a boundary consumes it
    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (rst)
        pend_q && live && !take |=> pend_q || !live);

endmodule

// File: rtl/iso_seq_fsm.sv
module iso_seq_fsm
    import iso_skip_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [AW-1:0] start_ptr,
    input  logic          cycle_start,
    input  logic          pend,
    output logic          take,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_valid,
    input  logic          fifo_empty,
    input  logic          fifo_we,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          active
);
    localparam logic [AW-1:0] A_PAY  = AW'(OFF_PAY);
    localparam logic [AW-1:0] A_BR   = AW'(OFF_BR);
    localparam logic [AW-1:0] A_SKIP = AW'(OFF_SKIP);

    seq_state_e    st;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] pay_q;
    logic          run_q;
    logic [AW-1:0] tgt;
    logic          tgt_ok;
    logic [AW-1:0] off;

    assign tgt    = {rd_data[AW-1:ZW], {ZW{1'b0}}};
    assign tgt_ok = z_valid(rd_data[ZW-1:0]);

    always_comb begin
        case (st)
            S_BR:    off = A_BR;
            S_SKIP:  off = A_SKIP;
            default: off = A_PAY;
        endcase
    end

    assign rd_req  = (st == S_PAY) || (st == S_BR) || (st == S_SKIP);
    assign rd_addr = ptr_q + off;
    assign take    = (st == S_WAIT) && cycle_start && run && pend;
    assign wr_stb  = (st == S_BR) && rd_valid;
    assign wr_data = pay_q;
    assign active  = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            ptr_q <= '0;
            pay_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= run;
            case (st)
                S_IDLE: begin
                    if (run && !run_q && z_valid(start_ptr[ZW-1:0])) begin
                        ptr_q <= {start_ptr[AW-1:ZW], {ZW{1'b0}}};
                        st    <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (cycle_start) begin
                        if (!run)
                            st <= S_IDLE;
                        else if (pend)
                            st <= S_SKIP;
                        else
                            st <= S_PAY;
                    end
                end
                S_PAY: begin
                    if (rd_valid) begin
                        pay_q <= rd_data;
                        st    <= S_BR;
                    end
                end
                S_BR, S_SKIP: begin
                    if (rd_valid) begin
                        if (tgt_ok) begin
                            ptr_q <= tgt;
                            st    <= S_WAIT;
                        end else begin
                            st <= S_DRAIN;
                        end
                    end
                end
                S_DRAIN: begin
                    if (cycle_start && !run)
                        st <= S_IDLE;
                    else if (fifo_empty && !fifo_we)
                        st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1: quiet right after reset
    assert_rst_quiet_R1: assert property (@(posedge clk)
        rst |=> !active && !rd_req);

    // R10: a request is held with a steady address until answered
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    // R9: run low at a boundary with no fetch in progress stops the context
    assert_run_stop_R9: assert property (@(posedge clk) disable iff (rst)
        cycle_start && !run && active && !rd_req |=> !active);

    // R6: a running context only ends once the FIFO was empty
    assert_drain_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(active) && $past(run) |-> $past(fifo_empty));

endmodule

// File: rtl/iso_fifo_wr.sv
module iso_fifo_wr #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    output logic          fifo_we,
    output logic [DW-1:0] fifo_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_we    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_we <= wr_stb;
            if (wr_stb)
                fifo_wdata <= wr_data;
        end
    end

    // R3: one write per program, never back to back
    assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_we |=> !fifo_we);

endmodule

// File: rtl/iso_tx_skip_seq.sv
module iso_tx_skip_seq #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [AW-1:0] start_ptr,
    output logic          active,
    input  logic          cycle_start,
    input  logic          bus_reset,
    input  logic          cycle_lost,
    input  logic          tx_error,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_valid,
    output logic          fifo_we,
    output logic [DW-1:0] fifo_wdata,
    output logic          fifo_flush,
    input  logic          fifo_empty
);
    logic          pend;
    logic          take;
    logic          wr_stb;
    logic [DW-1:0] wr_data;

    iso_evt_latch u_evt (
        .clk        (clk),
        .rst        (rst),
        .live       (active & run),
        .bus_reset  (bus_reset),
        .cycle_lost (cycle_lost),
        .tx_error   (tx_error),
        .take       (take),
        .pend       (pend),
        .flush      (fifo_flush)
    );

    iso_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .start_ptr   (start_ptr),
        .cycle_start (cycle_start),
        .pend        (pend),
        .take        (take),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .fifo_empty  (fifo_empty),
        .fifo_we     (fifo_we),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .active      (active)
    );

    iso_fifo_wr #(.DW(DW)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .fifo_we    (fifo_we),
        .fifo_wdata (fifo_wdata)
    );

    // R8: no flush is produced by an idle context
    assert_idle_noflush_R8: assert property (@(posedge clk) disable iff (rst)
        !active |=> !fifo_flush);

    // R7: a transmit error on a live context flushes in the next cycle
    assert_err_flush_R7: assert property (@(posedge clk) disable iff (rst)
        tx_error && active && run |=> fifo_flush);

endmodule

// File: tb/test_iso_tx_skip_seq.sv
module test_iso_tx_skip_seq;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic [AW-1:0] start_ptr = '0;
    logic          active;
    logic          cycle_start = 1'b0;
    logic          bus_reset = 1'b0;
    logic          cycle_lost = 1'b0;
    logic          tx_error = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          rd_valid = 1'b0;
    logic          fifo_we;
    logic [DW-1:0] fifo_wdata;
    logic          fifo_flush;
    logic          fifo_empty;

    always #10 clk = ~clk;

    iso_tx_skip_seq #(.AW(AW), .DW(DW)) i_iso_tx_skip_seq (
        .clk(clk), .rst(rst), .run(run), .start_ptr(start_ptr), .active(active),
        .cycle_start(cycle_start), .bus_reset(bus_reset), .cycle_lost(cycle_lost),
        .tx_error(tx_error), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .fifo_flush(fifo_flush), .fifo_empty(fifo_empty)
    );

    logic [31:0] mem [0:63];
    int n_total = 0, n_fail = 0;
    int n_wr, n_rd, n_fl, cnt = 0, lat = 0;
    logic [31:0] last_wdata;
    logic [AW-1:0] first_addr;

    // model state
    logic [AW-1:0] m_ptr;
    bit m_done, m_drain, m_act;

    assign fifo_empty = (cnt == 0);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // descriptor memory responder and FIFO model, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (fifo_we) begin
                n_wr++;
                last_wdata = fifo_wdata;
                cnt++;
            end
            if (fifo_flush) begin
                n_fl++;
                cnt = 0;
            end
            if (rd_valid) begin
                rd_valid = 1'b0;
            end else if (rd_req) begin
                if (lat == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[rd_addr[7:2]];
                    if (n_rd == 0) first_addr = rd_addr;
                    n_rd++;
                    lat = $urandom_range(0, 2);
                end else begin
                    lat--;
                end
            end
        end
    end

    function automatic logic [31:0] wd(input logic [AW-1:0] a);
        return mem[a[7:2]];
    endfunction

    // one bus cycle: optional event (0 none, 1 reset, 2 lost, 3 error)
    task automatic run_cycle(input int evt, input string req);
        int exp_wr, exp_rd, exp_fl;
        logic [31:0] exp_data, w;
        logic [AW-1:0] exp_addr;
        bit exp_act;
        exp_wr = 0; exp_rd = 0; exp_data = '0; exp_addr = '0;
        exp_fl = (evt == 3 && m_act && run) ? 1 : 0;
        if (m_done) begin
            exp_act = 1'b0;
            m_drain = 1'b0;
        end else if (evt != 0) begin
            exp_rd = 1; exp_addr = m_ptr + 16'd8;
            w = wd(exp_addr);
            if (w[3:0] == 4'h0) begin m_done = 1; exp_act = 0; end
            else begin m_ptr = {w[AW-1:4], 4'h0}; exp_act = 1; end
        end else begin
            exp_rd = 2; exp_addr = m_ptr; exp_wr = 1; exp_data = wd(m_ptr);
            w = wd(m_ptr + 16'd4);
            if (w[3:0] == 4'h0) begin m_done = 1; m_drain = 1; end
            else m_ptr = {w[AW-1:4], 4'h0};
            exp_act = 1;
        end
        n_wr = 0; n_rd = 0; n_fl = 0;
        if (evt != 0) begin
            bus_reset = (evt == 1); cycle_lost = (evt == 2); tx_error = (evt == 3);
            @(posedge clk); #2;
            bus_reset = 0; cycle_lost = 0; tx_error = 0;
            @(posedge clk); #2;
        end
        if (cnt > 0) cnt--;
        cycle_start = 1'b1;
        @(posedge clk); #2;
        cycle_start = 1'b0;
        repeat (16) @(posedge clk);
        #2;
        chk(n_wr == exp_wr, req, "write count", n_wr, exp_wr);
        if (exp_wr != 0) chk(last_wdata == exp_data, req, "packet word", last_wdata, exp_data);
        chk(n_rd == exp_rd, "R10", "read count", n_rd, exp_rd);
        if (exp_rd != 0) chk(first_addr == exp_addr, req, "first read address", first_addr, exp_addr);
        chk(n_fl == exp_fl, "R7", "flush count", n_fl, exp_fl);
        chk(active == exp_act, "R6", "active", active, exp_act);
        m_act = exp_act;
    endtask

    task automatic start_ctx(input logic [AW-1:0] a);
        run = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        start_ptr = a;
        run = 1'b1;
        @(posedge clk); #2;
        chk(active == (a[3:0] != 0), "R2", "active after start", active, a[3:0] != 0);
        m_ptr = {a[AW-1:4], 4'h0};
        m_done = (a[3:0] == 0); m_drain = 0; m_act = (a[3:0] != 0);
    endtask

    task automatic stop_ctx();
        run = 1'b0;
        n_wr = 0; n_rd = 0; n_fl = 0;
        cycle_start = 1'b1;
        @(posedge clk); #2;
        cycle_start = 1'b0;
        repeat (6) @(posedge clk);
        #2;
        chk(active == 1'b0, "R9", "active after run low", active, 0);
        chk(n_wr == 0 && n_rd == 0 && n_fl == 0, "R9", "activity after run low",
            n_wr + n_rd + n_fl, 0);
        m_act = 0; m_done = 1; m_drain = 0;
    endtask

    task automatic put_prog(input int k, input logic [31:0] br, input logic [31:0] sk);
        mem[k*4]     = 32'hA500_0000 | (k << 8) | 32'h11;
        mem[k*4 + 1] = br;
        mem[k*4 + 2] = sk;
        mem[k*4 + 3] = 32'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1394));
        for (int k = 0; k < 16; k++) put_prog(k, 32'h0, 32'h0);
        // P0 self skip, P1 skip to next, P2 skip elsewhere, P3 skip stop, P5 ends
        put_prog(0, 32'h11, 32'h01);
        put_prog(1, 32'h21, 32'h23);
        put_prog(2, 32'h31, 32'h51);
        put_prog(3, 32'h01, 32'h00);
        put_prog(5, 32'h00, 32'h11);
        repeat (3) @(posedge clk);
        #2;
        chk(!active && !rd_req && !fifo_we && !fifo_flush, "R1", "outputs in reset",
            {active, rd_req, fifo_we, fifo_flush}, 0);
        rst = 1'b0;
        @(posedge clk); #2;
        chk(!active && !rd_req && !fifo_we && !fifo_flush, "R1", "outputs after reset",
            {active, rd_req, fifo_we, fifo_flush}, 0);

        // R2: zero Z start is refused
        start_ctx(16'h0000);
        // R8: events while idle leave no trace
        bus_reset = 1; tx_error = 1; @(posedge clk); #2; bus_reset = 0; tx_error = 0;
        repeat (2) @(posedge clk); #2;
        chk(n_fl == 0 && !fifo_flush, "R8", "flush while idle", n_fl, 0);
        start_ctx(16'h0001);
        run_cycle(0, "R8");                       // normal write, no stale skip
        run_cycle(1, "R4");                       // P1 skip to next: P2
        run_cycle(1, "R4");                       // persistent: P2 skip elsewhere: P5
        run_cycle(0, "R3");                       // P5 written, branch ends
        run_cycle(0, "R6");                       // drained, inactive

        // R5: retry same packet
        start_ctx(16'h0002);
        run_cycle(2, "R5");
        run_cycle(0, "R5");
        run_cycle(0, "R3");
        // R7: error flushes and skips (ptr P2 -> P5)
        run_cycle(3, "R7");
        run_cycle(0, "R7");
        run_cycle(0, "R6");

        // R6: terminate via zero skip
        start_ctx(16'h0031);
        run_cycle(1, "R6");
        run_cycle(0, "R6");

        // R9: run drop
        start_ctx(16'h0001);
        run_cycle(0, "R3");
        stop_ctx();

        // random chains
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 16; k++) begin
                int ch;
                logic [31:0] br, sk;
                br = ($urandom_range(0, 9) == 0) ? 32'h0
                     : ((((k + 1) % 16) * 16) | $urandom_range(1, 15));
                ch = $urandom_range(0, 7);
                if (ch < 2)      sk = (k * 16) | $urandom_range(1, 15);
                else if (ch < 4) sk = (((k + 1) % 16) * 16) | 1;
                else if (ch < 7) sk = ($urandom_range(0, 15) * 16) | $urandom_range(1, 15);
                else             sk = $urandom_range(0, 15) * 16;
                put_prog(k, br, sk);
            end
            start_ctx(16'(($urandom_range(0, 15) * 16) | 1));
            for (int c = 0; c < 8; c++) begin
                int e;
                e = ($urandom_range(0, 9) < 3) ? $urandom_range(1, 3) : 0;
                run_cycle(e, e == 0 ? "R3" : "R4");
            end
            if (m_act) stop_ctx();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
        $finish;
    end
endmodule